// File: doc/BRIEF.md
# Compare-and-Condition Branch Evaluator

This block performs a compare of two operands by computing A minus B and keeps four status flags from that subtraction in a small register: negative, zero, carry and overflow. The carry follows the no-borrow convention, so it is set when A is greater than or equal to B as unsigned numbers. The flags stay as they are until the next compare strobe. This lets a branch sit many cycles away from the compare that decided it.

A 4-bit condition selector is tested against the stored flags at all times. It produces one `take_o` bit that says whether a branch under that condition would be taken. Signed and unsigned ordering, equality, sign and overflow tests all come from combinations of the four flags, so one compare serves every kind of ordering.

The compare strobe is a plain control pin and is never back-pressured. Every cycle in which it is high is accepted, and the flags it produces are visible from the next cycle on. The selector and the taken output are plain combinational status, with no handshake.

Top module: `branch_cond_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the flag register is cleared, so `flags_o` reads 4'b0000 in the next cycle.
- R2: The flag register loads only on a rising edge where `cmp_go` is high. In every other cycle `flags_o` holds its value, whatever the operands do.
- R3: After a compare, `flags_o[2]` (Z) is 1 exactly when the WIDTH-bit difference A-B is zero, and `flags_o[3]` (N) equals the top bit of that difference.
- R4: After a compare, `flags_o[1]` (C) is 1 exactly when A >= B as unsigned numbers, which means no borrow occurred.
- R5: After a compare, `flags_o[0]` (V) is 1 exactly when A-B overflows as a two's-complement subtraction. That is the case when the operand signs differ and the result sign differs from A.
- R6: Selector codes 0 EQ (Z), 1 NE (!Z), 4 MI (N), 5 PL (!N), 6 VS (V) and 7 VC (!V) make `take_o` follow a single flag.
- R7: Selector codes give the unsigned tests: 2 CS (C), 3 CC (!C), 8 HI (C and not Z) and 9 LS (not C, or Z).
- R8: Selector codes give the signed tests: 10 GE (N equals V), 11 LT (N differs from V), 12 GT (not Z, and N equals V) and 13 LE (Z, or N differs from V).
- R9: Selector 14 makes `take_o` 1 and selector 15 makes it 0, whatever the flags are.
- R10: `take_o` is combinational in the stored flags and the current `cond_sel`. A selector change shows up in the same cycle, and the result of a compare shows up in the cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmp_go | input | 1 | Compare strobe; flags load on this edge |
| opnd_a | input | WIDTH | Minuend A |
| opnd_b | input | WIDTH | Subtrahend B |
| cond_sel | input | 4 | Branch condition selector |
| flags_o | output | 4 | Stored flags {N, Z, C, V} |
| take_o | output | 1 | Condition holds on the stored flags |

## Verification
A wrong flag bit in the register shows up on `flags_o` one cycle after the compare strobe. For every selector that reads that bit, it also shows up on `take_o` in that same cycle. A register that reloads when no strobe is present shows up as a change on `flags_o` during cycles where only the operands moved. The reference model is checked every cycle, so such faults are caught within one clock. Operand pairs that sit at the signed and unsigned wrap points separate the carry bit from the overflow bit, because the two flags disagree there.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [3:0] {
    C_EQ = 4'd0,  C_NE = 4'd1,  C_CS = 4'd2,  C_CC = 4'd3,
    C_MI = 4'd4,  C_PL = 4'd5,  C_VS = 4'd6,  C_VC = 4'd7,
    C_HI = 4'd8,  C_LS = 4'd9,  C_GE = 4'd10, C_LT = 4'd11,
    C_GT = 4'd12, C_LE = 4'd13, C_AL = 4'd14, C_NV = 4'd15
  } cond_e;
endpackage

// File: rtl/cmp_subtract.sv
module cmp_subtract
  import cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output flags_t           flags_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   wide;
  logic [WIDTH-1:0] diff;

  always_comb begin
    wide      = {1'b0, a_i} - {1'b0, b_i};
    diff      = wide[MSB:0];
    flags_o.n = diff[MSB];
    flags_o.z = (diff == '0);
    flags_o.c = ~wide[WIDTH];
    flags_o.v = (a_i[MSB] ^ b_i[MSB]) & (diff[MSB] ^ a_i[MSB]);
  end
endmodule

// File: rtl/cmp_flag_reg.sv
module cmp_flag_reg
  import cmp_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk) begin
    if (rst)         q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(q_o));
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/cmp_cond_eval.sv
module cmp_cond_eval
  import cmp_pkg::*;
(
  input  flags_t     f_i,
  input  logic [3:0] sel_i,
  output logic       take_o
);
  logic nv_same;

  always_comb begin
    nv_same = (f_i.n == f_i.v);
    unique case (cond_e'(sel_i))
      C_EQ: take_o = f_i.z;
      C_NE: take_o = ~f_i.z;
      C_CS: take_o = f_i.c;
      C_CC: take_o = ~f_i.c;
      C_MI: take_o = f_i.n;
      C_PL: take_o = ~f_i.n;
      C_VS: take_o = f_i.v;
      C_VC: take_o = ~f_i.v;
      C_HI: take_o = f_i.c & ~f_i.z;
      C_LS: take_o = ~f_i.c | f_i.z;
      C_GE: take_o = nv_same;
      C_LT: take_o = ~nv_same;
      C_GT: take_o = ~f_i.z & nv_same;
      C_LE: take_o = f_i.z | ~nv_same;
      C_AL: take_o = 1'b1;
      default: take_o = 1'b0;
    endcase
  end

  always_comb begin
    if (sel_i == 4'd14) assert_always_R9: assert (take_o);
    if (sel_i == 4'd15) assert_never_R9: assert (!take_o);
  end
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
  import cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_go,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [3:0]       cond_sel,
  output logic [3:0]       flags_o,
  output logic             take_o
);
  flags_t next_f;
  flags_t cur_f;

  cmp_subtract #(.WIDTH(WIDTH)) u_sub (
    .a_i(opnd_a), .b_i(opnd_b), .flags_o(next_f)
  );

  cmp_flag_reg u_reg (
    .clk(clk), .rst(rst), .load_i(cmp_go), .d_i(next_f), .q_o(cur_f)
  );

  cmp_cond_eval u_eval (
    .f_i(cur_f), .sel_i(cond_sel), .take_o(take_o)
  );

  assign flags_o = cur_f;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (flags_o == 4'b0000));
  assert_zero_R3: assert property (@(posedge clk) disable iff (rst)
    cmp_go |=> (flags_o[2] == ($past(opnd_a) == $past(opnd_b))));
  assert_carry_R4: assert property (@(posedge clk) disable iff (rst)
    cmp_go |=> (flags_o[1] == ($past(opnd_a) >= $past(opnd_b))));
endmodule

// File: tb/sim_branch_cond_unit.sv
module sim_branch_cond_unit;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst;
  logic cmp_go;
  logic [W-1:0] opnd_a, opnd_b;
  logic [3:0] cond_sel;
  logic [3:0] flags_o;
  logic take_o;

  int n_cmp = 0;
  int n_bad = 0;
  int mn, mz, mc, mv;

  always #10 clk = ~clk;

  branch_cond_unit #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .cmp_go(cmp_go), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .cond_sel(cond_sel), .flags_o(flags_o), .take_o(take_o)
  );

  function automatic int ref_take(int c);
    case (c)
      0: return mz;       1: return !mz;
      2: return mc;       3: return !mc;
      4: return mn;       5: return !mn;
      6: return mv;       7: return !mv;
      8: return mc && !mz;
      9: return !mc || mz;
      10: return mn == mv;
      11: return mn != mv;
      12: return !mz && (mn == mv);
      13: return mz || (mn != mv);
      14: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int c);
    if (c == 2 || c == 3 || c == 8 || c == 9) return "R7";
    if (c >= 10 && c <= 13) return "R8";
    if (c >= 14) return "R9";
    return "R6";
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_flags(string tag);
    chk({tag, " R3 N"}, flags_o[3], mn);
    chk({tag, " R3 Z"}, flags_o[2], mz);
    chk({tag, " R4 C"}, flags_o[1], mc);
    chk({tag, " R5 V"}, flags_o[0], mv);
  endtask

  // one clock: drive at negedge, check take (R10 same cycle), then flags after edge
  task automatic step(logic go, int a, int b, int c);
    int d;
    cmp_go = go; opnd_a = W'(a); opnd_b = W'(b); cond_sel = 4'(c);
    #1;
    chk({tag_of(c), " R10 take"}, take_o, ref_take(c));
    @(posedge clk);
    if (go) begin
      d  = (a - b) & 255;
      mn = (d >> 7) & 1;
      mz = (d == 0);
      mc = (a >= b);
      mv = (((a ^ b) & 128) != 0) && (((d ^ a) & 128) != 0);
    end
    @(negedge clk);
    chk_flags(go ? "R2 load" : "R2 hold");
  endtask

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cmp_go = 1'b1; opnd_a = 8'h00; opnd_b = 8'h01; cond_sel = 4'd0;
    mn = 0; mz = 0; mc = 0; mv = 0;
    @(negedge clk); @(negedge clk);
    chk("R1 reset flags", flags_o, 0);
    rst = 1'b0;
    // directed corners
    step(1, 8'h40, 8'h40, 0);
    for (int c = 0; c < 16; c++) step(0, c * 17, 255 - c, c);  // hold, all selectors
    step(1, 8'h80, 8'h01, 10);   // V set, C set
    for (int c = 0; c < 16; c++) step(0, 3, 9, c);
    step(1, 8'h7f, 8'hff, 2);    // V set, N set, C clear
    for (int c = 0; c < 16; c++) step(0, 0, 0, c);
    step(1, 8'h01, 8'h02, 9);    // unsigned less, negative
    for (int c = 0; c < 16; c++) step(0, 200, 1, c);
    step(1, 8'hff, 8'h00, 12);   // signed -1 vs 0
    for (int c = 0; c < 16; c++) step(0, 7, 7, c);
    step(1, 8'h00, 8'h00, 13);
    // pseudo-random sweep with mixed strobes
    for (int i = 0; i < 400; i++)
      step(1'($urandom_range(0, 1)), $urandom_range(0, 255),
           $urandom_range(0, 255), $urandom_range(0, 15));
    // reset mid-run clears flags
    step(1, 8'h05, 8'h09, 3);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    mn = 0; mz = 0; mc = 0; mv = 0;
    chk("R1 reset again", flags_o, 0);
    for (int c = 0; c < 16; c++) step(0, 1, 2, c);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule